// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer whose write side and read side run on separate clocks. The clocks may be unrelated or may be the same net. A word enters on each write-clock rising edge that has `wr_en` high. A word leaves on each read-clock rising edge that has `rd_en` high, and it appears on a registered output. The read and write pointers cross between the domains as Gray code through two-flop synchronisers. For this reason each flag is conservative: it can lag a change made in the other domain, but it is never wrong in the unsafe direction.

There are five level flags. `empty`, `almost_empty` and the output register belong to the read clock. `full`, `almost_full` and `half_full` belong to the write clock. The two almost thresholds are held in an offset store, which is loaded through the ordinary data path. While `cfg_load` is high, each write fills the next quarter of the offset store instead of the FIFO. Each read while `cfg_load` is high returns the next quarter. The output-enable input does not drive any internal tristate. It is passed out as `rd_data_en`, and `rd_data` is gated to zero while it is low.

Top module: `dcfifo_pf`

## Requirements
- R1: After reset, `empty`=1, `almost_empty`=1, `full`=0, `half_full`=0, `almost_full`=0, `rd_data`=0 with `out_en` high, and both offsets are 7.
- R2: Words leave in the order they entered, with the write and read clocks running at unrelated frequencies.
- R3: `full` is 1 when the occupancy equals DEPTH. A write while full does not store its word.
- R4: `empty` is 1 when the occupancy is 0. A read while empty moves no pointer and leaves `rd_data` unchanged.
- R5: Take a word written into an empty FIFO. `empty` is still 1 just after the first read-clock edge that follows the write edge. It is 0 by the third read-clock edge.
- R6: `almost_empty` is 1 exactly when the occupancy is at most the empty offset.
- R7: `almost_full` is 1 exactly when DEPTH minus the occupancy is at most the full offset.
- R8: `half_full` is 1 exactly when the occupancy is greater than DEPTH/2.
- R9: While `cfg_load` is high, each write-clock edge with `wr_en` high stores the next slot of the offset store and then advances the slot. Here AW=log2(DEPTH) and L=ceil(AW/2). The slot order is: empty offset bits [L-1:0], empty offset bits [AW-1:L], full offset bits [L-1:0], full offset bits [AW-1:L]. Each slot takes the value from `wr_data[L-1:0]` (high slots use its lowest AW-L bits). After the fourth slot the order wraps to the first. The offsets change in no other way. With DEPTH=256, L=4.
- R10: While `cfg_load` is high, each read-clock edge with `rd_en` high puts the next slot onto the output register, zero-extended, in the same order as R9, with its own wrap.
- R11: While `cfg_load` is high, FIFO writes and reads are not performed: occupancy and flags do not change.
- R12: `rd_data_en` equals `out_en`. `rd_data` is 0 while `out_en` is low and is the output register while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset of both sides |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Word to store, or offset slot value in load mode |
| cfg_load | input | 1 | Selects the offset store instead of the FIFO |
| rd_en | input | 1 | Read request |
| out_en | input | 1 | Output drive enable |
| rd_data | output | 18 | Registered read word, zero while not enabled |
| rd_data_en | output | 1 | Drive indication for `rd_data` |
| empty | output | 1 | No word available (read clock) |
| almost_empty | output | 1 | Occupancy at or below empty offset (read clock) |
| half_full | output | 1 | More than half occupied (write clock) |
| almost_full | output | 1 | Free space at or below full offset (write clock) |
| full | output | 1 | No space left (write clock) |

## Verification
A corrupted pointer or synchroniser value shows at the ports as a wrong word, a duplicated word or a missing word on the very next read. Once both sides have had four clocks to settle, it also shows as a level flag that disagrees with the queue-held occupancy. A slot counter that slips in the offset store is seen at the first readback, and a wrong threshold is seen one word past the boundary. A premature empty release would expose a word that has not yet been written. The bench therefore samples `empty` one read edge after the write edge and again three read edges after it.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
  localparam int DATA_W    = 18;
  localparam int PTR_MAX_W = 13;

  typedef logic [PTR_MAX_W-1:0] ptr_t;

  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } ofs_slot_e;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(ptr_t g);
    ptr_t b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // modular distance from the consumer pointer to the producer pointer
  function automatic ptr_t fill_level(ptr_t prod, ptr_t cons);
    return prod - cons;
  endfunction
endpackage

// File: rtl/fifo_pf_sync2.sv
module fifo_pf_sync2 #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_pf_wr_ctl.sv
module fifo_pf_wr_ctl import fifo_pf_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          cfg_load,
  input  logic [PW-1:0] rgray_s,
  input  logic [AW-1:0] af_ofs,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_fire,
  output logic          full,
  output logic          almost_full,
  output logic          half_full
);
  logic [PW-1:0] wbin, wbin_nx, rbin_s, wocc, wfree;

  assign rbin_s      = PW'(gray2bin(ptr_t'(rgray_s)));
  assign wocc        = PW'(fill_level(ptr_t'(wbin), ptr_t'(rbin_s)));
  assign wfree       = PW'(DEPTH) - wocc;
  assign full        = (wocc == PW'(DEPTH));
  assign almost_full = (wfree <= {1'b0, af_ofs});
  assign half_full   = (wocc > PW'(DEPTH / 2));
  assign wr_fire     = wr_en & ~cfg_load & ~full;
  assign wbin_nx     = wbin + PW'(1);
  assign waddr       = wbin[AW-1:0];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_nx;
      wgray <= PW'(bin2gray(ptr_t'(wbin_nx)));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wocc <= PW'(DEPTH)); // R3
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(wbin)); // R3
  AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R2
  AST_LOAD_FREEZES_WPTR: assert property (@(posedge wr_clk) disable iff (!rst_n)
    cfg_load |=> $stable(wbin)); // R11
endmodule

// File: rtl/fifo_pf_rd_ctl.sv
module fifo_pf_rd_ctl import fifo_pf_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          cfg_load,
  input  logic [PW-1:0] wgray_s,
  input  logic [AW-1:0] ae_ofs,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          rd_fire,
  output logic          empty,
  output logic          almost_empty
);
  logic [PW-1:0] rbin, rbin_nx, wbin_s, rocc;

  assign wbin_s       = PW'(gray2bin(ptr_t'(wgray_s)));
  assign rocc         = PW'(fill_level(ptr_t'(wbin_s), ptr_t'(rbin)));
  assign empty        = (rocc == '0);
  assign almost_empty = (rocc <= {1'b0, ae_ofs});
  assign rd_fire      = rd_en & ~cfg_load & ~empty;
  assign rbin_nx      = rbin + PW'(1);
  assign raddr        = rbin[AW-1:0];

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_fire) begin
      rbin  <= rbin_nx;
      rgray <= PW'(bin2gray(ptr_t'(rbin_nx)));
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rocc <= PW'(DEPTH)); // R4
  AST_EMPTY_BLOCKS_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty && rd_en) |=> $stable(rbin)); // R4
  AST_RGRAY_ONE_BIT: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R2
  AST_LOAD_FREEZES_RPTR: assert property (@(posedge rd_clk) disable iff (!rst_n)
    cfg_load |=> $stable(rbin)); // R11
endmodule

// File: rtl/fifo_pf_ofs_regs.sv
module fifo_pf_ofs_regs import fifo_pf_pkg::*; #(
  parameter int AW     = 8,
  parameter int PART_W = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PART_W-1:0] part_in,
  output logic [AW-1:0]     ae_ofs,
  output logic [AW-1:0]     af_ofs,
  output logic              ld_rd_fire,
  output logic [DATA_W-1:0] rb_word
);
  localparam int HI_W = AW - PART_W;
  localparam logic [AW-1:0] OFS_RESET = AW'(7);

  ofs_slot_e wslot, rslot;
  logic      ld_wr_fire;

  assign ld_wr_fire = cfg_load & wr_en;
  assign ld_rd_fire = cfg_load & rd_en;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wslot  <= SLOT_AE_LO;
      ae_ofs <= OFS_RESET;
      af_ofs <= OFS_RESET;
    end else if (ld_wr_fire) begin
      unique case (wslot)
        SLOT_AE_LO: ae_ofs[PART_W-1:0]  <= part_in;
        SLOT_AE_HI: ae_ofs[AW-1:PART_W] <= part_in[HI_W-1:0];
        SLOT_AF_LO: af_ofs[PART_W-1:0]  <= part_in;
        SLOT_AF_HI: af_ofs[AW-1:PART_W] <= part_in[HI_W-1:0];
      endcase
      wslot <= ofs_slot_e'(wslot + 2'd1);
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rslot <= SLOT_AE_LO;
    end else if (ld_rd_fire) begin
      rslot <= ofs_slot_e'(rslot + 2'd1);
    end
  end

  always_comb begin
    unique case (rslot)
      SLOT_AE_LO: rb_word = DATA_W'(ae_ofs[PART_W-1:0]);
      SLOT_AE_HI: rb_word = DATA_W'(ae_ofs[AW-1:PART_W]);
      SLOT_AF_LO: rb_word = DATA_W'(af_ofs[PART_W-1:0]);
      SLOT_AF_HI: rb_word = DATA_W'(af_ofs[AW-1:PART_W]);
    endcase
  end

  AST_OFS_ONLY_BY_LOAD: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !ld_wr_fire |=> ($stable(ae_ofs) && $stable(af_ofs))); // R9
  AST_WSLOT_WRAP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (ld_wr_fire && wslot == SLOT_AF_HI) |=> wslot == SLOT_AE_LO); // R9
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf import fifo_pf_pkg::*; #(
  parameter int DEPTH = 256
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_load,
  input  logic              rd_en,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_en,
  output logic              empty,
  output logic              almost_empty,
  output logic              half_full,
  output logic              almost_full,
  output logic              full
);
  localparam int AW     = $clog2(DEPTH);
  localparam int PW     = AW + 1;
  localparam int PART_W = (AW + 1) / 2;

  initial begin
    if (DEPTH < 256 || DEPTH > 4096 || (DEPTH & (DEPTH - 1)) != 0)
      $error("dcfifo_pf: DEPTH must be a power of two from 256 to 4096");
  end

  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]     waddr, raddr, ae_ofs, af_ofs;
  logic              wr_fire, rd_fire, ld_rd_fire;
  logic [DATA_W-1:0] rb_word, q;
  logic [DATA_W-1:0] mem [DEPTH];

  fifo_pf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_load(cfg_load),
    .rgray_s(rgray_s), .af_ofs(af_ofs), .wgray(wgray), .waddr(waddr),
    .wr_fire(wr_fire), .full(full), .almost_full(almost_full),
    .half_full(half_full)
  );

  fifo_pf_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .cfg_load(cfg_load),
    .wgray_s(wgray_s), .ae_ofs(ae_ofs), .rgray(rgray), .raddr(raddr),
    .rd_fire(rd_fire), .empty(empty), .almost_empty(almost_empty)
  );

  fifo_pf_sync2 #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  fifo_pf_sync2 #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  fifo_pf_ofs_regs #(.AW(AW), .PART_W(PART_W)) u_ofs (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .wr_en(wr_en), .rd_en(rd_en), .part_in(wr_data[PART_W-1:0]),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ld_rd_fire(ld_rd_fire),
    .rb_word(rb_word)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (rd_fire)    q <= mem[raddr];
    else if (ld_rd_fire) q <= rb_word;
  end

  assign rd_data    = out_en ? q : '0;
  assign rd_data_en = out_en;

  AST_EMPTY_HOLDS_Q: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty && rd_en && !cfg_load) |=> $stable(q)); // R4
endmodule

// File: tb/dcfifo_pf_tb.sv
`timescale 1ns/100ps
module dcfifo_pf_tb_top;
  localparam int DEPTH = 256;
  localparam int NSTEP = 10;
  // each step: {op (1 = write burst, 0 = read burst), word count}
  localparam int STEP [NSTEP][2] = '{
    '{1, 5}, '{1, 3}, '{0, 1}, '{1, 121}, '{1, 1},
    '{1, 119}, '{1, 1}, '{1, 7}, '{0, 200}, '{0, 56}
  };

  logic        wclk = 0, rclk = 0, rst_n = 0;
  logic        wr_en = 0, cfg_load = 0, rd_en = 0, out_en = 1;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic        rd_data_en, empty, almost_empty, half_full, almost_full, full;

  int          n_chk = 0, n_bad = 0, seq = 0, ae_o = 7, af_o = 7;
  bit          done = 0;
  logic [17:0] model [$];
  logic [17:0] last;

  always #4 wclk = ~wclk;
  initial begin
    #0.3;
    forever #5.5 rclk = ~rclk;
  end

  dcfifo_pf #(.DEPTH(DEPTH)) dut_i (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .cfg_load(cfg_load), .rd_en(rd_en), .out_en(out_en),
    .rd_data(rd_data), .rd_data_en(rd_data_en), .empty(empty),
    .almost_empty(almost_empty), .half_full(half_full),
    .almost_full(almost_full), .full(full)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic check_flags();
    int occ = model.size();
    chk("R4", "empty", int'(empty), int'(occ == 0));
    chk("R3", "full", int'(full), int'(occ == DEPTH));
    chk("R8", "half_full", int'(half_full), int'(occ > DEPTH / 2));
    chk("R6", "almost_empty", int'(almost_empty), int'(occ <= ae_o));
    chk("R7", "almost_full", int'(almost_full), int'(DEPTH - occ <= af_o));
  endtask

  task automatic push(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      seq++;
      wr_en   = 1;
      wr_data = 18'h20000 | 18'(seq);
      model.push_back(wr_data);
    end
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic raw_write(input logic [17:0] d);
    @(negedge wclk);
    wr_en   = 1;
    wr_data = d;
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic pop(input int n, input string req);
    @(negedge rclk);
    rd_en = 1;
    for (int i = 0; i < n; i++) begin
      logic [17:0] exp;
      @(negedge rclk);
      exp = model.pop_front();
      chk(req, "read word", int'(rd_data), int'(exp));
      last = exp;
      if (i == n - 1) rd_en = 0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge wclk);
    rst_n = 1;
    settle();
    // R1 reset state
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "almost_empty", int'(almost_empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "half_full", int'(half_full), 0);
    chk("R1", "almost_full", int'(almost_full), 0);
    chk("R1", "rd_data", int'(rd_data), 0);

    // vector table: bursts with flag checks (R2 data order, R3/R4/R6/R7/R8 flags)
    for (int s = 0; s < NSTEP; s++) begin
      if (STEP[s][0] == 1) push(STEP[s][1]);
      else pop(STEP[s][1], "R2");
      settle();
      check_flags();
    end

    // R5 empty release across domains
    @(negedge wclk);
    seq++;
    wr_en   = 1;
    wr_data = 18'h20000 | 18'(seq);
    model.push_back(wr_data);
    @(posedge wclk);
    fork
      begin #1 wr_en = 0; end
      begin
        @(posedge rclk); #1 chk("R5", "empty after first read edge", int'(empty), 1);
        @(posedge rclk);
        @(posedge rclk); #1 chk("R5", "empty after third read edge", int'(empty), 0);
      end
    join
    pop(1, "R5");
    settle();

    // R3 writes while full are dropped
    push(DEPTH);
    settle();
    chk("R3", "full at depth", int'(full), 1);
    raw_write(18'h3FFFF);
    raw_write(18'h00001);
    raw_write(18'h12345);
    settle();
    check_flags();
    pop(DEPTH, "R3");
    settle();
    check_flags();

    // R4 reads while empty are ignored
    @(negedge rclk);
    rd_en = 1;
    repeat (2) @(negedge rclk);
    rd_en = 0;
    chk("R4", "rd_data holds on empty read", int'(rd_data), int'(last));
    settle();
    chk("R4", "still empty", int'(empty), 1);
    push(1);
    settle();
    pop(1, "R4");
    settle();

    // R9 R10 R11 offset store load and readback
    cfg_load = 1;
    settle();
    raw_write(18'h00004);  // empty offset low part
    raw_write(18'h00001);  // empty offset high part -> 20
    raw_write(18'h0000E);  // full offset low part
    raw_write(18'h00001);  // full offset high part -> 30
    settle();
    chk("R11", "empty stays set in load mode", int'(empty), 1);
    chk("R11", "half_full stays clear in load mode", int'(half_full), 0);
    @(negedge rclk);
    rd_en = 1;
    for (int i = 0; i < 4; i++) begin
      int exp_rb [4] = '{4, 1, 14, 1};
      @(negedge rclk);
      chk("R10", "readback slot", int'(rd_data), exp_rb[i]);
      if (i == 3) rd_en = 0;
    end
    raw_write(18'h00002);  // wraps to empty offset low part -> 18
    @(negedge rclk);
    rd_en = 1;
    @(negedge rclk);
    rd_en = 0;
    chk("R9", "slot wrap rewrote empty low part", int'(rd_data), 2);
    cfg_load = 0;
    ae_o = 18;
    af_o = 30;
    settle();
    check_flags();

    // R6 R7 thresholds from loaded offsets
    push(18);  settle(); check_flags();
    push(1);   settle(); check_flags();
    push(206); settle(); check_flags();
    push(1);   settle(); check_flags();
    pop(226, "R2");
    settle();
    check_flags();

    // R12 output enable
    out_en = 0;
    #1;
    chk("R12", "rd_data_en low", int'(rd_data_en), 0);
    chk("R12", "rd_data gated", int'(rd_data), 0);
    out_en = 1;
    #1;
    chk("R12", "rd_data_en high", int'(rd_data_en), 1);
    chk("R12", "rd_data restored", int'(rd_data), int'(last));

    finish_run();
  end
endmodule